// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Pair Joining

This block drives six pulse-width outputs from 8-bit period and duty settings. All six channels share one prescaler. A channel's counter advances once per prescaler tick, and its output stays high while the count is below the duty setting. Software sets the enables, the pairing field and the per-channel period and duty values through a simple write/read port.

Any of the pairs (0,1), (2,3) and (4,5) can be joined into one 16-bit channel. In a joined pair the even channel supplies the upper byte of the period and duty, and its own output is held low. The odd channel's enable alone starts and stops the joined channel, and the 16-bit waveform appears on the odd channel's output. An enable that has just been set only starts the waveform at the next prescaler tick. When every enable bit is clear, the prescaler is held at zero.

Top module: `pwm6_concat`

## Requirements
- R1: Address 0 holds the six enable bits in bits 5..0 and resets to zero. Bits 7..6 read as 0 whatever is written to them.
- R2: Each running channel counts 0 to period-1 on each tick, and its output is high while count < duty. A duty of 0 gives constant low. A duty of period or more (with a nonzero duty) gives constant high.
- R3: A channel's output stays low after its enable is set. The channel starts at the first prescaler tick after the write, with its counter at 0.
- R4: When pair p is joined (bit p of address 1 set), the even channel's output is 0 and its enable bit has no effect.
- R5: In a joined pair, period = {even period, odd period} and duty = {even duty, odd duty}, each as 16 bits. The odd channel's enable controls the pair, and the 16-bit waveform appears on the odd channel's output.
- R6: Clearing a channel's enable drives its output low at the next clock edge. The channel then restarts with its counter at 0.
- R7: While all six enable bits are 0, the prescaler is held at zero. After an enable is set from the all-clear state, the first tick falls DIV cycles after the write edge.
- R8: Period and duty writes go to holding registers. These take effect at the counter wrap, or at once while the channel is stopped. Reads return the last value written.
- R9: Register map: address 1 bits 2..0 hold the pair-joining field, and the upper bits read 0. Addresses 2+i hold the period of channel i and addresses 8+i hold its duty. All other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | AW (4) | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| pwmOut | output | 6 | Channel outputs, bit i is channel i |

## Verification
A corrupted counter or a misloaded period or duty register changes the duty pattern. That error reaches pwmOut within one tick, which is at most DIV cycles, or within one period if the fault is in a holding register. A run flag with the wrong value leaves an output low or high for a whole tick. The waveform is compared on every cycle, so the fault is caught on its first cycle. A prescaler that fails to stop shows up as a change in the start latency of the next enable. A wrong pairing decode shows up as activity on a forced-off even output.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int NUM_PAIRS  = 3;
  localparam int NUM_CH     = 2 * NUM_PAIRS;
  localparam int DW         = 8;
  localparam int ADDR_EN    = 0;
  localparam int ADDR_CAT   = 1;
  localparam int ADDR_PER0  = 2;
  localparam int ADDR_DUTY0 = ADDR_PER0 + NUM_CH;

  typedef struct packed {
    logic                 tick;
    logic [NUM_CH-1:0]    run;
    logic [NUM_PAIRS-1:0] cat;
    logic [NUM_CH-1:0]    perWe;
    logic [NUM_CH-1:0]    dutyWe;
    logic [DW-1:0]        wdata;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm6_ctrl.sv
module pwm6_ctrl
  import pwm6_pkg::*;
#(
  parameter int DIV = 4,
  parameter int AW  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [AW-1:0]        regAddr,
  input  logic [DW-1:0]        regWdata,
  output pwmStrobe_t           stb,
  output logic [NUM_CH-1:0]    enVal,
  output logic [NUM_PAIRS-1:0] catVal
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [NUM_CH-1:0]    enReg, enNext, effEn, runReg;
  logic [NUM_PAIRS-1:0] catReg, catNext;
  logic [PW-1:0]        preCnt;
  logic                 wrEn, wrCat, anyEn, tick;

  assign wrEn    = regWe && (regAddr == AW'(ADDR_EN));
  assign wrCat   = regWe && (regAddr == AW'(ADDR_CAT));
  assign enNext  = wrEn  ? regWdata[NUM_CH-1:0]    : enReg;
  assign catNext = wrCat ? regWdata[NUM_PAIRS-1:0] : catReg;
  assign anyEn   = |enReg;
  assign tick    = anyEn && (preCnt == PRE_LAST);

  // In a joined pair the even enable is masked off.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_eff
    assign effEn[2*p]   = enNext[2*p] && !catNext[p];
    assign effEn[2*p+1] = enNext[2*p+1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= '0;
      catReg <= '0;
      preCnt <= '0;
      runReg <= '0;
    end else begin
      enReg  <= enNext;
      catReg <= catNext;
      if (!anyEn || preCnt == PRE_LAST) preCnt <= '0;
      else                              preCnt <= preCnt + PW'(1);
      for (int i = 0; i < NUM_CH; i++)
        runReg[i] <= effEn[i] && (runReg[i] || tick);
    end
  end

  always_comb begin
    stb.tick  = tick;
    stb.run   = runReg;
    stb.cat   = catReg;
    stb.wdata = regWdata;
    for (int i = 0; i < NUM_CH; i++) begin
      stb.perWe[i]  = regWe && (regAddr == AW'(ADDR_PER0 + i));
      stb.dutyWe[i] = regWe && (regAddr == AW'(ADDR_DUTY0 + i));
    end
  end

  assign enVal  = enReg;
  assign catVal = catReg;
endmodule

// File: rtl/pwm6_pair_dp.sv
module pwm6_pair_dp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          catOn,
  input  logic          runA,
  input  logic          runB,
  input  logic          perWeA,
  input  logic          perWeB,
  input  logic          dutWeA,
  input  logic          dutWeB,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] shPerA,
  output logic [DW-1:0] shPerB,
  output logic [DW-1:0] shDutA,
  output logic [DW-1:0] shDutB,
  output logic          outA,
  output logic          outB
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] actPerA, actPerB, actDutA, actDutB, cntA, cntB;
  logic [CW-1:0] cnt16, per16, dut16;
  logic          wrapA, wrapB, wrap16, loadA, loadB;
  logic          cmpA, cmpB, cmp16;

  assign cnt16 = {cntA, cntB};
  assign per16 = {actPerA, actPerB};
  assign dut16 = {actDutA, actDutB};

  assign wrapA  = ({1'b0, cntA}  + (DW+1)'(1)) >= {1'b0, actPerA};
  assign wrapB  = ({1'b0, cntB}  + (DW+1)'(1)) >= {1'b0, actPerB};
  assign wrap16 = ({1'b0, cnt16} + (CW+1)'(1)) >= {1'b0, per16};

  assign cmpA  = (actDutA != '0) && ((actDutA >= actPerA) || (cntA  < actDutA));
  assign cmpB  = (actDutB != '0) && ((actDutB >= actPerB) || (cntB  < actDutB));
  assign cmp16 = (dut16   != '0) && ((dut16   >= per16)   || (cnt16 < dut16));

  assign loadA = catOn ? (!runB || (tick && wrap16)) : (!runA || (tick && wrapA));
  assign loadB = catOn ? (!runB || (tick && wrap16)) : (!runB || (tick && wrapB));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntA <= '0;
      cntB <= '0;
    end else if (catOn) begin
      if (!runB)     {cntA, cntB} <= '0;
      else if (tick) {cntA, cntB} <= wrap16 ? '0 : cnt16 + CW'(1);
    end else begin
      if (!runA)     cntA <= '0;
      else if (tick) cntA <= wrapA ? '0 : cntA + DW'(1);
      if (!runB)     cntB <= '0;
      else if (tick) cntB <= wrapB ? '0 : cntB + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPerA <= '0; shPerB <= '0; shDutA <= '0; shDutB <= '0;
      actPerA <= '0; actPerB <= '0; actDutA <= '0; actDutB <= '0;
    end else begin
      if (perWeA) shPerA <= wdata;
      if (perWeB) shPerB <= wdata;
      if (dutWeA) shDutA <= wdata;
      if (dutWeB) shDutB <= wdata;
      if (loadA) begin actPerA <= shPerA; actDutA <= shDutA; end
      if (loadB) begin actPerB <= shPerB; actDutB <= shDutB; end
    end
  end

  assign outA = !catOn && runA && cmpA;
  assign outB = runB && (catOn ? cmp16 : cmpB);
endmodule

// File: rtl/pwm6_datapath.sv
module pwm6_datapath
  import pwm6_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pwmStrobe_t           stb,
  output logic [NUM_CH*DW-1:0] perRd,
  output logic [NUM_CH*DW-1:0] dutRd,
  output logic [NUM_CH-1:0]    pwmOut
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pwm6_pair_dp #(.DW(DW)) u_pair (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (stb.tick),
      .catOn  (stb.cat[p]),
      .runA   (stb.run[2*p]),
      .runB   (stb.run[2*p+1]),
      .perWeA (stb.perWe[2*p]),
      .perWeB (stb.perWe[2*p+1]),
      .dutWeA (stb.dutyWe[2*p]),
      .dutWeB (stb.dutyWe[2*p+1]),
      .wdata  (stb.wdata),
      .shPerA (perRd[(2*p)*DW +: DW]),
      .shPerB (perRd[(2*p+1)*DW +: DW]),
      .shDutA (dutRd[(2*p)*DW +: DW]),
      .shDutB (dutRd[(2*p+1)*DW +: DW]),
      .outA   (pwmOut[2*p]),
      .outB   (pwmOut[2*p+1])
    );
  end
endmodule

// File: rtl/pwm6_concat.sv
module pwm6_concat
  import pwm6_pkg::*;
#(
  parameter int DIV = 4,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [AW-1:0]     regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmStrobe_t           stb;
  logic [NUM_CH-1:0]    enVal;
  logic [NUM_PAIRS-1:0] catVal;
  logic [NUM_CH*DW-1:0] perRd, dutRd;

  pwm6_ctrl #(.DIV(DIV), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .stb      (stb),
    .enVal    (enVal),
    .catVal   (catVal)
  );

  pwm6_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .perRd  (perRd),
    .dutRd  (dutRd),
    .pwmOut (pwmOut)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == AW'(ADDR_EN))  regRdata = DW'(enVal);
    if (regAddr == AW'(ADDR_CAT)) regRdata = DW'(catVal);
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == AW'(ADDR_PER0 + i))  regRdata = perRd[i*DW +: DW];
      if (regAddr == AW'(ADDR_DUTY0 + i)) regRdata = dutRd[i*DW +: DW];
    end
  end
endmodule

// File: rtl/pwm6_checker.sv
module pwm6_checker
  import pwm6_pkg::*;
#(
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [AW-1:0]     regAddr,
  input logic [DW-1:0]     regWdata,
  input logic [NUM_CH-1:0] pwmOut,
  input pwmStrobe_t        stb
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R6: a cleared enable silences the output after one edge
    a_r6_clear_low: assert property (@(posedge clk) disable iff (!rstN)
      (regWe && regAddr == AW'(ADDR_EN) && !regWdata[i]) |=> !pwmOut[i]);
    // R3: a channel only starts after a prescaler tick
    a_r3_start_on_tick: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stb.run[i]) |-> $past(stb.tick));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    // R4: the even output of a joined pair stays low
    a_r4_even_off: assert property (@(posedge clk) disable iff (!rstN)
      stb.cat[p] |-> !pwmOut[2*p]);
  end

  // R7: no tick once every enable has been cleared
  a_r7_prescaler_stop: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == AW'(ADDR_EN) && regWdata[NUM_CH-1:0] == '0) |=> !stb.tick);
endmodule

bind pwm6_concat pwm6_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .pwmOut   (pwmOut),
  .stb      (stb)
);

// File: tb/tb_pwm6_concat.sv
`timescale 1ns/1ps
module tb_pwm6_concat;
  localparam int DIV = 4;
  localparam int AW  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [5:0] pwmOut;

  int    nChk = 0;
  int    nFail = 0;
  bit    cmpOn = 1'b0;
  string curTag = "R2";

  always #2 clk = ~clk;

  pwm6_concat #(.DIV(DIV), .AW(AW)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut)
  );

  // ---------------- reference model from the requirements ----------------
  logic [5:0] mEn;
  logic [2:0] mCat;
  int         mPre;
  logic [5:0] mRun;
  logic [7:0] mCnt[6], mShP[6], mShD[6], mAcP[6], mAcD[6];

  function automatic bit pwmLevel(int c, int per, int dut);
    return (dut != 0) && ((dut >= per) || (c < dut));
  endfunction

  function automatic bit expOut(int ch);
    int a, b;
    a = (ch / 2) * 2; b = a + 1;
    if (mCat[ch/2]) begin
      if (ch == a) return 1'b0;
      return mRun[b] && pwmLevel({mCnt[a], mCnt[b]}, {mAcP[a], mAcP[b]}, {mAcD[a], mAcD[b]});
    end
    return mRun[ch] && pwmLevel(mCnt[ch], mAcP[ch], mAcD[ch]);
  endfunction

  function automatic logic [7:0] expRead(logic [3:0] ad);
    if (ad == 0) return {2'b00, mEn};
    if (ad == 1) return {5'b0, mCat};
    if (ad >= 2 && ad < 8)  return mShP[ad-2];
    if (ad >= 8 && ad < 14) return mShD[ad-8];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = '0; mCat = '0; mPre = 0; mRun = '0;
      for (int i = 0; i < 6; i++) begin
        mCnt[i] = 0; mShP[i] = 0; mShD[i] = 0; mAcP[i] = 0; mAcD[i] = 0;
      end
    end else begin
      logic [5:0] enN, runN;
      logic [2:0] catN;
      logic [7:0] cntN[6], acPN[6], acDN[6];
      bit tk;
      enN  = (regWe && regAddr == 0) ? regWdata[5:0] : mEn;
      catN = (regWe && regAddr == 1) ? regWdata[2:0] : mCat;
      tk   = (mEn != 0) && (mPre == DIV - 1);
      for (int ch = 0; ch < 6; ch++) begin
        bit eff;
        eff = (ch % 2 == 1) ? enN[ch] : (enN[ch] && !catN[ch/2]);
        runN[ch] = eff && (mRun[ch] || tk);
        cntN[ch] = mCnt[ch]; acPN[ch] = mAcP[ch]; acDN[ch] = mAcD[ch];
      end
      for (int p = 0; p < 3; p++) begin
        int a, b;
        a = 2*p; b = a + 1;
        if (mCat[p]) begin
          int c16, p16;
          bit w, ld;
          c16 = {mCnt[a], mCnt[b]}; p16 = {mAcP[a], mAcP[b]};
          w = (c16 + 1) >= p16;
          if (!mRun[b]) c16 = 0;
          else if (tk) c16 = w ? 0 : c16 + 1;
          cntN[a] = c16[15:8]; cntN[b] = c16[7:0];
          ld = !mRun[b] || (tk && w);
          if (ld) begin
            acPN[a] = mShP[a]; acDN[a] = mShD[a];
            acPN[b] = mShP[b]; acDN[b] = mShD[b];
          end
        end else begin
          for (int x = a; x <= b; x++) begin
            bit w;
            w = (int'(mCnt[x]) + 1) >= int'(mAcP[x]);
            if (!mRun[x]) cntN[x] = 0;
            else if (tk) cntN[x] = w ? 8'd0 : mCnt[x] + 8'd1;
            if (!mRun[x] || (tk && w)) begin acPN[x] = mShP[x]; acDN[x] = mShD[x]; end
          end
        end
      end
      mPre = (mEn == 0) ? 0 : ((mPre == DIV - 1) ? 0 : mPre + 1);
      mEn = enN; mCat = catN; mRun = runN;
      for (int i = 0; i < 6; i++) begin
        mCnt[i] = cntN[i]; mAcP[i] = acPN[i]; mAcD[i] = acDN[i];
      end
      if (regWe && regAddr >= 2 && regAddr < 8)  mShP[regAddr-2] = regWdata;
      if (regWe && regAddr >= 8 && regAddr < 14) mShD[regAddr-8] = regWdata;
    end
  end

  // ---------------- checking ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [5:0] e;
      for (int ch = 0; ch < 6; ch++) e[ch] = expOut(ch);
      check(curTag, 32'(pwmOut), 32'(e), "pwmOut");
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdCheck(string tag, logic [3:0] a);
    regAddr = a;
    #1;
    check(tag, 32'(regRdata), 32'(expRead(a)), "regRdata");
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    check("R1", 32'(pwmOut), 0, "pwmOut after reset");
    for (int a = 0; a < 16; a++) rdCheck("R1", 4'(a));
    cmpOn = 1'b1;

    // R1: reserved bits read back zero
    curTag = "R1";
    wr(0, 8'hC0);
    regAddr = 0; #1; check("R1", 32'(regRdata), 0, "reserved enable bits");
    wr(1, 8'hF8);
    regAddr = 1; #1; check("R9", 32'(regRdata), 0, "upper joining bits");
    wr(15, 8'hAA); wr(14, 8'h55);
    rdCheck("R9", 15); rdCheck("R9", 14);

    // R7 / R3: start latency from the all-clear state
    curTag = "R3";
    wr(2, 8'd5); wr(8, 8'd5);
    idle(3);
    wr(0, 8'h01);
    for (int k = 0; k <= DIV; k++) begin
      check("R7", 32'(pwmOut[0]), (k == DIV) ? 1 : 0, "first tick latency");
      @(negedge clk);
    end

    // R2: several duty relations
    curTag = "R2";
    wr(8, 8'd2);
    wr(3, 8'd6); wr(9, 8'd0);
    wr(4, 8'd4); wr(10, 8'd9);
    wr(5, 8'd7); wr(11, 8'd3);
    wr(0, 8'h0F);
    idle(120);

    // R8: buffered period change while running
    curTag = "R8";
    wr(2, 8'd9); rdCheck("R8", 2);
    wr(8, 8'd4); rdCheck("R8", 8);
    idle(100);

    // R6: disable and re-enable
    curTag = "R6";
    wr(0, 8'h0E);
    check("R6", 32'(pwmOut[0]), 0, "output after clear");
    idle(10);
    wr(0, 8'h0F);
    idle(60);

    // R4 / R5: join pair 2
    curTag = "R4";
    wr(0, 8'h00); idle(4);
    wr(1, 8'h04);
    wr(6, 8'h00); wr(7, 8'h20);
    wr(12, 8'h00); wr(13, 8'h0C);
    wr(0, 8'h10);
    for (int k = 0; k < 40; k++) begin
      check("R4", 32'(pwmOut), 0, "ignored even enable");
      @(negedge clk);
    end
    curTag = "R5";
    wr(0, 8'h30);
    idle(300);
    wr(12, 8'h01); wr(6, 8'h01);
    idle(1400);

    // random mix
    curTag = "R2";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      regWe = 1'b0;
      if ($urandom_range(0, 5) == 0) begin
        logic [3:0] a;
        a = 4'($urandom_range(0, 15));
        regWe = 1'b1; regAddr = a;
        regWdata = (a >= 2 && a < 14) ? 8'($urandom_range(0, 11)) : 8'($urandom);
      end else begin
        rdCheck("R9", 4'($urandom_range(0, 15)));
      end
    end
    @(negedge clk); regWe = 1'b0;
    idle(4);
    cmpOn = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule